// File: doc/BRIEF.md
# Block-Fetch DMA Engine

This engine moves square tiles of an image from system memory into the input RAM of a transform accelerator, so that the processor does not have to copy pixels itself. Software programs a start address, the line pitch of the image in bytes and the number of tiles across and down, then writes a start bit. The engine becomes a bus master. For each tile it reads every row as a short incrementing burst and writes each returned word into the accelerator RAM at the word's position inside the tile.

After a tile is complete the engine keeps the bus and waits until the accelerator reports that it has taken the tile. It then fetches the next tile. Tiles are walked left to right along a band of lines, then one band down. After the last tile has been accepted the engine drops the bus for one cycle, returns to idle and raises a done flag. While the engine is idle, the RAM write port follows a separate processor-side write path, so the accelerator can still be loaded by software.

Top module: `blkdma_fetch`

## Requirements
- R1: After reset, cyc, stb and the RAM write enable are low, and every register reads zero, including the status word (bit 0 busy, bit 1 done).
- R2: The register port stores the source address at index 0, the line pitch in bytes at index 1 (low 16 bits), and the tile counts at index 2 (tiles across in bits 15:0, tiles down in bits 31:16). Each reads back as written.
- R3: Writing 1 to bit 0 at index 3 while idle, with both tile counts non-zero, takes cyc high and sets busy in the very next cycle, and clears done.
- R4: Tile k (across count X) has base src + (k div X)·8·pitch + (k mod X)·8. Beat b of a tile reads address base + (b div 2)·pitch + (b mod 2)·4, with tiles and beats taken in increasing order.
- R5: Each returned word is written to the RAM at address b (0..15) with the bus data, and the write enable is high only in the cycle in which ack arrives for that beat.
- R6: Every strobed beat is a read with all byte selects set. Its cycle-type code is 010 on the first word of a row and 111 on the second word.
- R7: Between tiles, stb is low and cyc stays high until the ready input is seen. The next tile's first beat is strobed in the cycle after ready.
- R8: After the last tile, ready takes cyc low in the next cycle while busy still reads 1. One cycle later busy reads 0 and done reads 1.
- R9: While idle, the RAM write enable, address and data outputs follow the processor-side write inputs.
- R10: A start while either tile count is zero is ignored: busy stays 0 and cyc stays low.
- R11: A start written while busy does not restart the walk. The address sequence of R4 continues unchanged.
- R12: The tile-loaded output pulses exactly in the cycle of the last ack of each tile.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register index |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational) |
| wb_cyc_o | output | 1 | Bus cycle in progress |
| wb_stb_o | output | 1 | Bus strobe |
| wb_we_o | output | 1 | Bus write enable (always 0) |
| wb_sel_o | output | 4 | Byte selects |
| wb_adr_o | output | 32 | Bus byte address |
| wb_cti_o | output | 3 | Bus cycle-type code |
| wb_dat_i | input | 32 | Bus read data |
| wb_ack_i | input | 1 | Bus acknowledge |
| acc_ready_i | input | 1 | Accelerator has consumed the current tile |
| blk_loaded_o | output | 1 | Pulse on the last word of a tile |
| cpu_ram_we_i | input | 1 | Processor-side RAM write enable |
| cpu_ram_addr_i | input | 4 | Processor-side RAM address |
| cpu_ram_data_i | input | 32 | Processor-side RAM data |
| ram_we_o | output | 1 | Accelerator RAM write enable |
| ram_addr_o | output | 4 | Accelerator RAM word address |
| ram_data_o | output | 32 | Accelerator RAM write data |

## Verification
The bench builds the engine with its default geometry: eight rows of two 32-bit words, which gives sixteen beats per tile and a four-bit RAM address. With that geometry it runs a 3-by-2 tile walk, which covers moving along a band and dropping to the next band. It also runs a single-tile walk, in which the first tile is also the last. The bus model acks either in the same cycle as the strobe or one cycle later, so both back-to-back and stretched beats occur. The ready input is held off for several cycles, and the processor-side write path is held active during a walk.

// File: rtl/blkdma_pkg.sv
package blkdma_pkg;

    parameter int ADDR_W = 32;
    parameter int DATA_W = 32;
    parameter int CNT_W  = 16;

    localparam int BYTES_PER_WORD = DATA_W / 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GETBLOCK,
        ST_WAITREADY,
        ST_WAITREADY_LAST,
        ST_RELEASEBUS
    } dma_state_e;

    localparam logic [2:0] CTI_CLASSIC = 3'b000;
    localparam logic [2:0] CTI_CONST   = 3'b001;
    localparam logic [2:0] CTI_INCR    = 3'b010;
    localparam logic [2:0] CTI_END     = 3'b111;

    localparam logic [1:0] REG_SRC   = 2'd0;
    localparam logic [1:0] REG_PITCH = 2'd1;
    localparam logic [1:0] REG_COUNT = 2'd2;
    localparam logic [1:0] REG_CTRL  = 2'd3;

    typedef struct packed {
        logic [ADDR_W-1:0] src;
        logic [CNT_W-1:0]  pitch;
        logic [CNT_W-1:0]  cols;
        logic [CNT_W-1:0]  rows;
    } job_cfg_t;

    function automatic logic [2:0] beat_cti(input logic last_word);
        return last_word ? CTI_END : CTI_INCR;
    endfunction

endpackage

// File: rtl/blkdma_csr.sv
module blkdma_csr
    import blkdma_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    input  logic              busy,
    input  logic              start_taken,
    input  logic              done_set,
    output logic              start_req,
    output job_cfg_t          job
);

    logic done_q;

    assign start_req = cfg_we && (cfg_addr == REG_CTRL) && cfg_wdata[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            job    <= '0;
            done_q <= 1'b0;
        end else begin
            if (cfg_we) begin
                case (cfg_addr)
                    REG_SRC:   job.src   <= cfg_wdata[ADDR_W-1:0];
                    REG_PITCH: job.pitch <= cfg_wdata[CNT_W-1:0];
                    REG_COUNT: begin
                        job.cols <= cfg_wdata[CNT_W-1:0];
                        job.rows <= cfg_wdata[2*CNT_W-1:CNT_W];
                    end
                    default: ;
                endcase
            end
            if (start_taken)
                done_q <= 1'b0;
            else if (done_set)
                done_q <= 1'b1;
        end
    end

    always_comb begin
        case (cfg_addr)
            REG_SRC:   cfg_rdata = DATA_W'(job.src);
            REG_PITCH: cfg_rdata = DATA_W'(job.pitch);
            REG_COUNT: cfg_rdata = DATA_W'({job.rows, job.cols});
            default:   cfg_rdata = DATA_W'({done_q, busy});
        endcase
    end

endmodule

// File: rtl/blkdma_ctrl.sv
module blkdma_ctrl
    import blkdma_pkg::*;
#(
    parameter int ROWS = 8,
    parameter int WPR  = 2,
    localparam int RW  = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int WW  = (WPR > 1) ? $clog2(WPR) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_req,
    input  logic          job_ok,
    input  logic          ack,
    input  logic          acc_ready,
    input  logic          last_blk,
    output dma_state_e    state,
    output logic [RW-1:0] row_idx,
    output logic [WW-1:0] word_idx,
    output logic          bus_cyc,
    output logic          bus_stb,
    output logic [2:0]    bus_cti,
    output logic          beat_we,
    output logic          row_done,
    output logic          blk_done,
    output logic          load,
    output logic          advance,
    output logic          done_set
);

    localparam logic [RW-1:0] ROW_LAST  = RW'(ROWS - 1);
    localparam logic [WW-1:0] WORD_LAST = WW'(WPR - 1);

    dma_state_e state_n;
    logic       last_word, last_row;

    assign last_word = (word_idx == WORD_LAST);
    assign last_row  = (row_idx == ROW_LAST);

    assign bus_stb  = (state == ST_GETBLOCK);
    assign bus_cyc  = (state == ST_GETBLOCK) || (state == ST_WAITREADY) ||
                      (state == ST_WAITREADY_LAST);
    assign bus_cti  = bus_stb ? beat_cti(last_word) : CTI_CLASSIC;
    assign beat_we  = bus_stb && ack;
    assign row_done = beat_we && last_word;
    assign blk_done = row_done && last_row;
    assign load     = (state == ST_IDLE) && start_req && job_ok;
    assign advance  = (state == ST_WAITREADY) && acc_ready;
    assign done_set = (state == ST_RELEASEBUS);

    always_comb begin
        state_n = state;
        case (state)
            ST_IDLE:           if (load) state_n = ST_GETBLOCK;
            ST_GETBLOCK:       if (blk_done)
                                   state_n = last_blk ? ST_WAITREADY_LAST : ST_WAITREADY;
            ST_WAITREADY:      if (acc_ready) state_n = ST_GETBLOCK;
            ST_WAITREADY_LAST: if (acc_ready) state_n = ST_RELEASEBUS;
            ST_RELEASEBUS:     state_n = ST_IDLE;
            default:           state_n = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            row_idx  <= '0;
            word_idx <= '0;
        end else begin
            state <= state_n;
            if (load) begin
                row_idx  <= '0;
                word_idx <= '0;
            end else if (beat_we) begin
                word_idx <= last_word ? '0 : word_idx + WW'(1);
                if (last_word)
                    row_idx <= last_row ? '0 : row_idx + RW'(1);
            end
        end
    end

endmodule

// File: rtl/blkdma_addr.sv
module blkdma_addr
    import blkdma_pkg::*;
#(
    parameter int ROWS = 8,
    parameter int WPR  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              advance,
    input  logic              row_done,
    input  job_cfg_t          job,
    output logic [ADDR_W-1:0] line_adr,
    output logic              last_blk
);

    localparam int BLK_STEP = WPR * BYTES_PER_WORD;

    logic [ADDR_W-1:0] blk_q, band_q, band_step, next_blk;
    logic [CNT_W-1:0]  col_q, brow_q;
    logic              last_col, last_band;

    assign last_col  = (col_q == job.cols - CNT_W'(1));
    assign last_band = (brow_q == job.rows - CNT_W'(1));
    assign last_blk  = last_col && last_band;
    assign band_step = ADDR_W'(ADDR_W'(job.pitch) * ADDR_W'(ROWS));
    assign next_blk  = last_col ? band_q + band_step : blk_q + ADDR_W'(BLK_STEP);

    always_ff @(posedge clk) begin
        if (rst) begin
            blk_q    <= '0;
            band_q   <= '0;
            line_adr <= '0;
            col_q    <= '0;
            brow_q   <= '0;
        end else if (load) begin
            blk_q    <= job.src;
            band_q   <= job.src;
            line_adr <= job.src;
            col_q    <= '0;
            brow_q   <= '0;
        end else if (advance) begin
            blk_q    <= next_blk;
            line_adr <= next_blk;
            if (last_col) begin
                band_q <= band_q + band_step;
                col_q  <= '0;
                brow_q <= brow_q + CNT_W'(1);
            end else begin
                col_q <= col_q + CNT_W'(1);
            end
        end else if (row_done) begin
            line_adr <= line_adr + ADDR_W'(job.pitch);
        end
    end

endmodule

// File: rtl/blkdma_fetch.sv
module blkdma_fetch
    import blkdma_pkg::*;
#(
    parameter int ROWS = 8,
    parameter int WPR  = 2,
    localparam int RAM_AW = $clog2(ROWS * WPR),
    localparam int RW  = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int WW  = (WPR > 1) ? $clog2(WPR) : 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      cfg_we,
    input  logic [1:0]                cfg_addr,
    input  logic [DATA_W-1:0]         cfg_wdata,
    output logic [DATA_W-1:0]         cfg_rdata,
    output logic                      wb_cyc_o,
    output logic                      wb_stb_o,
    output logic                      wb_we_o,
    output logic [BYTES_PER_WORD-1:0] wb_sel_o,
    output logic [ADDR_W-1:0]         wb_adr_o,
    output logic [2:0]                wb_cti_o,
    input  logic [DATA_W-1:0]         wb_dat_i,
    input  logic                      wb_ack_i,
    input  logic                      acc_ready_i,
    output logic                      blk_loaded_o,
    input  logic                      cpu_ram_we_i,
    input  logic [RAM_AW-1:0]         cpu_ram_addr_i,
    input  logic [DATA_W-1:0]         cpu_ram_data_i,
    output logic                      ram_we_o,
    output logic [RAM_AW-1:0]         ram_addr_o,
    output logic [DATA_W-1:0]         ram_data_o
);

    job_cfg_t          job;
    dma_state_e        state;
    logic [RW-1:0]     row_idx;
    logic [WW-1:0]     word_idx;
    logic [ADDR_W-1:0] line_adr;
    logic [RAM_AW-1:0] beat_idx;
    logic start_req, job_ok, last_blk, beat_we, row_done;
    logic load, advance, done_set, busy;

    assign busy   = (state != ST_IDLE);
    assign job_ok = (job.cols != '0) && (job.rows != '0);

    blkdma_csr u_csr (
        .clk, .rst, .cfg_we, .cfg_addr, .cfg_wdata, .cfg_rdata,
        .busy, .start_taken(load), .done_set, .start_req, .job
    );

    blkdma_ctrl #(.ROWS(ROWS), .WPR(WPR)) u_ctrl (
        .clk, .rst, .start_req, .job_ok, .ack(wb_ack_i),
        .acc_ready(acc_ready_i), .last_blk, .state, .row_idx, .word_idx,
        .bus_cyc(wb_cyc_o), .bus_stb(wb_stb_o), .bus_cti(wb_cti_o),
        .beat_we, .row_done, .blk_done(blk_loaded_o), .load, .advance,
        .done_set
    );

    blkdma_addr #(.ROWS(ROWS), .WPR(WPR)) u_addr (
        .clk, .rst, .load, .advance, .row_done, .job, .line_adr, .last_blk
    );

    assign wb_we_o  = 1'b0;
    assign wb_sel_o = '1;
    assign wb_adr_o = line_adr + ADDR_W'(int'(word_idx) * BYTES_PER_WORD);
    assign beat_idx = RAM_AW'(int'(row_idx) * WPR + int'(word_idx));

    always_comb begin
        if (busy) begin
            ram_we_o   = beat_we;
            ram_addr_o = beat_idx;
            ram_data_o = wb_dat_i;
        end else begin
            ram_we_o   = cpu_ram_we_i;
            ram_addr_o = cpu_ram_addr_i;
            ram_data_o = cpu_ram_data_i;
        end
    end

endmodule

// File: rtl/blkdma_checks.sv
module blkdma_checks
    import blkdma_pkg::*;
(
    input logic                      clk,
    input logic                      rst,
    input logic                      cyc,
    input logic                      stb,
    input logic                      we,
    input logic [BYTES_PER_WORD-1:0] sel,
    input logic [2:0]                cti,
    input logic [ADDR_W-1:0]         adr,
    input logic                      ack,
    input logic                      ready,
    input logic                      loaded,
    input logic                      ram_we
);

    // R5: while the engine owns the bus, RAM writes happen only on acked beats
    a_r5_we_on_ack: assert property (@(posedge clk) disable iff (rst)
        (cyc && !(stb && ack)) |-> !ram_we);

    // R6: strobed beats are full-width reads with a burst code
    a_r6_beat_form: assert property (@(posedge clk) disable iff (rst)
        stb |-> (!we && (sel == '1) && ((cti == CTI_INCR) || (cti == CTI_END))));

    // R6: an unacked beat holds its address and strobe
    a_r6_hold_beat: assert property (@(posedge clk) disable iff (rst)
        (stb && !ack) |=> (stb && $stable(adr)));

    // R7: between tiles the bus stays owned and idle until ready
    a_r7_hold_bus: assert property (@(posedge clk) disable iff (rst)
        (cyc && !stb && !ready) |=> (cyc && !stb));

    // R12: tile-loaded pulse only on an acked beat
    a_r12_pulse_on_ack: assert property (@(posedge clk) disable iff (rst)
        loaded |-> (stb && ack));

    // R8: a released bus stays released for at least one more cycle
    a_r8_release: assert property (@(posedge clk) disable iff (rst)
        $fell(cyc) |=> !cyc);

endmodule

bind blkdma_fetch blkdma_checks u_chk (
    .clk(clk), .rst(rst), .cyc(wb_cyc_o), .stb(wb_stb_o), .we(wb_we_o),
    .sel(wb_sel_o), .cti(wb_cti_o), .adr(wb_adr_o), .ack(wb_ack_i),
    .ready(acc_ready_i), .loaded(blk_loaded_o), .ram_we(ram_we_o)
);

// File: tb/blkdma_fetch_tb_top.sv
module blkdma_fetch_tb_top;
    import blkdma_pkg::*;

    logic        clk = 1'b0;
    logic        rst;
    logic        cfg_we;
    logic [1:0]  cfg_addr;
    logic [31:0] cfg_wdata, cfg_rdata;
    logic        wb_cyc_o, wb_stb_o, wb_we_o, wb_ack_i;
    logic [3:0]  wb_sel_o;
    logic [31:0] wb_adr_o, wb_dat_i;
    logic [2:0]  wb_cti_o;
    logic        acc_ready_i, blk_loaded_o;
    logic        cpu_ram_we_i, ram_we_o;
    logic [3:0]  cpu_ram_addr_i, ram_addr_o;
    logic [31:0] cpu_ram_data_i, ram_data_o;

    int n_checks = 0;
    int n_fail   = 0;

    bit          ack_late = 1'b0;
    logic        ack_q;
    bit          mon_on = 1'b0;
    int          mon_k, mon_b, mon_bx;
    logic [31:0] mon_src, mon_w;

    always #10 clk = ~clk;

    blkdma_fetch dut_i (
        .clk, .rst, .cfg_we, .cfg_addr, .cfg_wdata, .cfg_rdata,
        .wb_cyc_o, .wb_stb_o, .wb_we_o, .wb_sel_o, .wb_adr_o, .wb_cti_o,
        .wb_dat_i, .wb_ack_i, .acc_ready_i, .blk_loaded_o,
        .cpu_ram_we_i, .cpu_ram_addr_i, .cpu_ram_data_i,
        .ram_we_o, .ram_addr_o, .ram_data_o
    );

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return {a[15:0], ~a[15:0]};
    endfunction

    // bus slave model: same-cycle or one-cycle-late acknowledge
    always_ff @(posedge clk) begin
        if (rst) ack_q <= 1'b0;
        else     ack_q <= wb_stb_o && wb_cyc_o && !ack_q;
    end
    assign wb_ack_i = ack_late ? (ack_q && wb_stb_o) : (wb_stb_o && wb_cyc_o);
    assign wb_dat_i = mem_word(wb_adr_o);

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // beat monitor: R4, R5, R6, R12
    always @(negedge clk) begin
        if (!rst && mon_on && wb_cyc_o) begin
            automatic bit exp_we = wb_stb_o && wb_ack_i;
            check(ram_we_o == exp_we, "R5", "ram write enable", {31'd0, ram_we_o}, {31'd0, exp_we});
            if (exp_we) begin
                automatic int          row  = mon_b / 2;
                automatic int          word = mon_b % 2;
                automatic logic [31:0] base = mon_src + 32'((mon_k / mon_bx) * 8) * mon_w
                                              + 32'((mon_k % mon_bx) * 8);
                automatic logic [31:0] ea   = base + 32'(row) * mon_w + 32'(word * 4);
                check(wb_adr_o == ea, "R4", "beat address", wb_adr_o, ea);
                check(ram_addr_o == 4'(mon_b), "R5", "ram address", {28'd0, ram_addr_o}, 32'(mon_b));
                check(ram_data_o == mem_word(ea), "R5", "ram data", ram_data_o, mem_word(ea));
                check(wb_cti_o == (word == 1 ? 3'b111 : 3'b010), "R6", "cycle type",
                      {29'd0, wb_cti_o}, (word == 1) ? 32'd7 : 32'd2);
                check(blk_loaded_o == (mon_b == 15), "R12", "tile loaded pulse",
                      {31'd0, blk_loaded_o}, {31'd0, (mon_b == 15)});
                if (mon_b == 15) begin
                    mon_b = 0;
                    mon_k = mon_k + 1;
                end else begin
                    mon_b = mon_b + 1;
                end
            end
        end
    end

    task automatic write_reg(input logic [1:0] a, input logic [31:0] d);
        cfg_addr  = a;
        cfg_wdata = d;
        cfg_we    = 1'b1;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    task automatic read_reg(input logic [1:0] a, output logic [31:0] d);
        cfg_addr = a;
        #1;
        d = cfg_rdata;
    endtask

    task automatic test_reset();
        logic [31:0] v;
        check(!wb_cyc_o && !wb_stb_o, "R1", "cyc/stb after reset", {30'd0, wb_cyc_o, wb_stb_o}, 0);
        check(!ram_we_o, "R1", "ram we after reset", {31'd0, ram_we_o}, 0);
        for (int i = 0; i < 4; i++) begin
            read_reg(2'(i), v);
            check(v == 0, "R1", "register after reset", v, 0);
        end
    endtask

    task automatic test_regs();
        logic [31:0] v;
        write_reg(2'd0, 32'h1234_5670);
        write_reg(2'd1, 32'h0000_0140);
        write_reg(2'd2, 32'h0005_0007);
        read_reg(2'd0, v); check(v == 32'h1234_5670, "R2", "source readback", v, 32'h1234_5670);
        read_reg(2'd1, v); check(v == 32'h0000_0140, "R2", "pitch readback", v, 32'h0000_0140);
        read_reg(2'd2, v); check(v == 32'h0005_0007, "R2", "count readback", v, 32'h0005_0007);
    endtask

    task automatic test_cpu_path();
        cpu_ram_we_i   = 1'b1;
        cpu_ram_addr_i = 4'd5;
        cpu_ram_data_i = 32'hCAFE_F00D;
        #1;
        check(ram_we_o && ram_addr_o == 4'd5, "R9", "idle passthrough we/addr",
              {27'd0, ram_we_o, ram_addr_o}, 32'h15);
        check(ram_data_o == 32'hCAFE_F00D, "R9", "idle passthrough data", ram_data_o, 32'hCAFE_F00D);
        cpu_ram_we_i = 1'b0;
        #1;
        check(!ram_we_o, "R9", "idle passthrough we low", {31'd0, ram_we_o}, 0);
    endtask

    task automatic test_zero_count();
        logic [31:0] v;
        write_reg(2'd2, 32'h0003_0000);
        write_reg(2'd3, 32'h1);
        read_reg(2'd3, v);
        check(v[0] == 1'b0 && !wb_cyc_o, "R10", "start with zero tiles across", v, 0);
        write_reg(2'd2, 32'h0000_0002);
        write_reg(2'd3, 32'h1);
        read_reg(2'd3, v);
        check(v[0] == 1'b0 && !wb_cyc_o, "R10", "start with zero tiles down", v, 0);
    endtask

    task automatic run_job(input logic [31:0] src, input logic [31:0] w, input int bx,
                           input int by, input bit late, input int hold, input bit restart);
        logic [31:0] v;
        int guard;
        ack_late = late;
        write_reg(2'd0, src);
        write_reg(2'd1, w);
        write_reg(2'd2, {16'(by), 16'(bx)});
        mon_src = src; mon_w = w; mon_bx = bx; mon_k = 0; mon_b = 0;
        mon_on  = 1'b1;
        cpu_ram_we_i = 1'b1;
        cpu_ram_data_i = 32'hDEAD_BEEF;
        write_reg(2'd3, 32'h1);
        read_reg(2'd3, v);
        check(wb_cyc_o && v[1:0] == 2'b01, "R3", "start: cyc, busy, done cleared",
              {29'd0, wb_cyc_o, v[1:0]}, 32'h5);
        for (int k = 0; k < bx * by; k++) begin
            guard = 0;
            while (!blk_loaded_o && guard < 500) begin
                @(negedge clk);
                guard++;
            end
            check(guard < 500, "R12", "tile completion seen", 32'(guard), 0);
            @(negedge clk);
            if (restart && k == 0) write_reg(2'd3, 32'h1);   // R11 start ignored while busy
            for (int h = 0; h < hold; h++) begin
                check(wb_cyc_o && !wb_stb_o, "R7", "bus held idle before ready",
                      {30'd0, wb_cyc_o, wb_stb_o}, 32'h2);
                @(negedge clk);
            end
            acc_ready_i = 1'b1;
            @(negedge clk);
            acc_ready_i = 1'b0;
            if (k < bx * by - 1) begin
                check(wb_cyc_o && wb_stb_o, "R7", "fetch resumes after ready",
                      {30'd0, wb_cyc_o, wb_stb_o}, 32'h3);
            end else begin
                read_reg(2'd3, v);
                check(!wb_cyc_o && v[0], "R8", "bus released, still busy",
                      {30'd0, wb_cyc_o, v[0]}, 32'h1);
                @(negedge clk);
                read_reg(2'd3, v);
                check(v[1:0] == 2'b10, "R8", "idle with done", v, 32'h2);
            end
        end
        check(mon_k == bx * by && mon_b == 0, "R11", "tile count fetched", 32'(mon_k), 32'(bx * by));
        mon_on = 1'b0;
        cpu_ram_we_i = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        rst = 1'b1;
        cfg_we = 1'b0; cfg_addr = 2'd0; cfg_wdata = '0;
        acc_ready_i = 1'b0;
        cpu_ram_we_i = 1'b0; cpu_ram_addr_i = '0; cpu_ram_data_i = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        test_reset();
        test_regs();
        test_cpu_path();
        test_zero_count();
        run_job(32'h0000_1000, 32'd64, 3, 2, 1'b0, 3, 1'b0);
        run_job(32'h0002_0010, 32'd16, 1, 1, 1'b1, 2, 1'b1);
        run_job(32'h0000_4000, 32'd40, 2, 1, 1'b1, 1, 1'b1);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule